// File: doc/BRIEF.md
# Data-Strobe Link Receiver

This block turns an incoming data/strobe signal pair into link characters. The bit clock is not sent as a separate line, so it is recovered from the pair. Each change of the exclusive-OR of the two lines marks one new bit, and that bit's value is the level of the data line. After reset the receiver discards bits until it has seen a complete NULL. From that point it frames characters. A data character is ten bits long and a control character is four; the second bit of each character tells which kind it is.

Decoded characters are sorted by kind. Data bytes and end-of-packet markers go to a 9-bit FIFO write port. A flow-control token sends a one-cycle credit pulse to the local transmitter. A NULL sends a one-cycle pulse to the link state machine as evidence that the far end is alive. A time code is presented on its own port with a valid strobe and is not written to the FIFO. Packets have no start marker, so the byte after an end marker simply opens the next packet.

The receiver reports three kinds of error to the link state machine, each as a one-cycle pulse: a parity error, an illegal escape sequence, and a disconnect (no new bit within 850 ns). After any error the receiver drops its framing and hunts for a NULL again.

Top module: `ds_link_rx`

## Requirements
- R1: While reset is held and after it is released, every output is low. While both lines stay constant, no event and no error is produced, however long the idle lasts.
- R2: A bit is taken each time the exclusive-OR of data and strobe changes, and its value is the data level. Bits are discarded until the seven-bit tail 1,1,1,0,1,0,0 of a NULL has arrived. That NULL is reported with one `null_seen` pulse. Its first parity bit is not checked.
- R3: Each character is sent as a parity bit, then a flag bit. A flag of 0 is followed by eight data bits, LSB first. A flag of 1 is followed by two control bits. In the order they are sent, these control bits are 0,0 for FCT, 0,1 for EOP, 1,0 for EEP and 1,1 for ESC.
- R4: A data character not preceded by ESC gives one `fifo_wr` pulse with `fifo_wdata` = {1'b0, byte}. EOP writes 9'h100 and EEP writes 9'h101.
- R5: An FCT not preceded by ESC gives exactly one `credit` pulse and no FIFO write.
- R6: ESC followed by FCT (a NULL) gives one `null_seen` pulse and no other event.
- R7: ESC followed by a data character gives one `tc_valid` pulse with that byte on `tc_value` and no FIFO write.
- R8: Odd parity applies: the XOR of the previous character's data or control bits, the current parity bit and the current flag bit must be 1. On a mismatch `err_par` pulses, the character is dropped, and bits are discarded until the next NULL.
- R9: ESC followed by ESC, EOP or EEP pulses `err_esc`. Bits are then discarded until the next NULL.
- R10: Once a first bit has arrived, going DISC_CYC = ceil(850 ns / clock period) cycles without a new bit pulses `err_disc` and restarts the NULL hunt. The timer then idles until the next bit. Shorter gaps produce no error, and characters are accepted again after a new NULL.
- R11: At most one of `fifo_wr`, `credit`, `null_seen`, `tc_valid` and `err_esc` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_d | input | 1 | Incoming data line |
| rx_s | input | 1 | Incoming strobe line |
| fifo_wr | output | 1 | One-cycle write strobe to the receive FIFO |
| fifo_wdata | output | 9 | Bit 8 marks an end marker; bits 7:0 hold the byte, or 0 for EOP and 1 for EEP |
| credit | output | 1 | One-cycle pulse per received FCT |
| null_seen | output | 1 | One-cycle pulse per received NULL |
| tc_valid | output | 1 | One-cycle pulse per received time code |
| tc_value | output | 8 | Value of the most recent time code |
| err_par | output | 1 | One-cycle parity error pulse |
| err_esc | output | 1 | One-cycle escape error pulse |
| err_disc | output | 1 | One-cycle disconnect error pulse |

## Verification
The assertions assume that the two lines never both change within the same synchronizer window. Under that assumption two bit events are always several cycles apart, and a character completes only in a cycle that carries a bit. The stimulus meets this by holding every bit for six clock cycles and changing only one line per bit, which is how data/strobe coding works. The error pulses are assumed to be one cycle wide and separate from decoded events. The bench never sends a character in the cycles around an error, so an error and a decoded event never coincide.

// File: rtl/ds_rx_pkg.sv
// Package: shared codes and helpers for the data-strobe receiver.
// Assumes control bits are stored with the first-sent bit in position 0.
package ds_rx_pkg;

    // Control code as {second bit, first bit}.
    typedef enum logic [1:0] {
        CTL_FCT = 2'b00,
        CTL_EEP = 2'b01,
        CTL_EOP = 2'b10,
        CTL_ESC = 2'b11
    } ctl_code_t;

    // Last seven bits of a NULL, oldest bit in the MSB.
    localparam logic [6:0] NULL_TAIL = 7'b1110100;

    // Character lengths in bits, parity and flag included.
    localparam int CTRL_LEN = 4;
    localparam int DATA_LEN = 10;

    // Cycles that make up the disconnect window, rounded up.
    function automatic int disc_limit(input int window_ns, input int clk_ps);
        return (window_ns * 1000 + clk_ps - 1) / clk_ps;
    endfunction

endpackage

// File: rtl/ds_bit_recover.sv
// Module: ds_bit_recover
// Synchronizes the data and strobe lines and emits one bit event each time
// their XOR changes. Also runs the disconnect timer.
// Assumes: SYNC_STAGES >= 2 and bit periods longer than the synchronizer.
module ds_bit_recover #(
    parameter int SYNC_STAGES = 2,
    parameter int DISC_CYC    = 213
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_d,
    input  logic rx_s,
    output logic bit_vld,
    output logic bit_val,
    output logic disc_err
);
    localparam int TW = $clog2(DISC_CYC + 1);

    logic [SYNC_STAGES-1:0] d_pipe;
    logic [SYNC_STAGES-1:0] s_pipe;
    logic                   x_prev;
    logic                   armed;
    logic [TW-1:0]          idle_cnt;
    logic                   d_now;
    logic                   s_now;

    // Purpose: bring both lines into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_pipe <= '0;
            s_pipe <= '0;
        end else begin
            d_pipe <= {d_pipe[SYNC_STAGES-2:0], rx_d};
            s_pipe <= {s_pipe[SYNC_STAGES-2:0], rx_s};
        end
    end

    assign d_now   = d_pipe[SYNC_STAGES-1];
    assign s_now   = s_pipe[SYNC_STAGES-1];
    assign bit_vld = (d_now ^ s_now) != x_prev;
    assign bit_val = d_now;

    // Purpose: remember the last XOR level to spot the next bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_prev <= 1'b0;
        end else begin
            x_prev <= d_now ^ s_now;
        end
    end

    // Purpose: count idle cycles after the first bit and flag a disconnect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            idle_cnt <= '0;
            disc_err <= 1'b0;
        end else begin
            disc_err <= 1'b0;
            if (bit_vld) begin
                armed    <= 1'b1;
                idle_cnt <= '0;
            end else if (armed) begin
                if (idle_cnt == TW'(DISC_CYC - 1)) begin
                    disc_err <= 1'b1;
                    armed    <= 1'b0;
                    idle_cnt <= '0;
                end else begin
                    idle_cnt <= idle_cnt + 1'b1;
                end
            end
        end
    end

    // R10: a bit in this cycle means no disconnect in the next.
    p_disc_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld |=> !disc_err);

    // R10: the disconnect flag is a single-cycle pulse.
    p_disc_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        disc_err |=> !disc_err);

endmodule

// File: rtl/ds_char_frame.sv
// Module: ds_char_frame
// Hunts for a NULL tail, then frames bits into characters and checks parity.
// Assumes bit events are never on consecutive cycles (guaranteed upstream).
module ds_char_frame
    import ds_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_vld,
    input  logic       bit_val,
    input  logic       resync,
    output logic       chr_vld,
    output logic       chr_ctrl,
    output logic [7:0] chr_data,
    output logic       align_null,
    output logic       par_err
);
    logic       aligned;
    logic [6:0] hist;
    logic [3:0] cnt;
    logic       par_b;
    logic       flag;
    logic [7:0] payload;
    logic       px_run;
    logic       prev_px;

    logic [2:0] cnt_idx;
    logic [7:0] pay_next;
    logic [6:0] hist_next;
    logic       is_last;
    logic       par_good;
    logic       px_next;

    // Purpose: next-state helpers for the shift, end of character and parity.
    always_comb begin
        cnt_idx           = 3'(cnt - 4'd2);
        pay_next          = payload;
        pay_next[cnt_idx] = bit_val;
        hist_next         = {hist[5:0], bit_val};
        is_last           = (cnt >= 4'd2) &&
                            (flag ? (cnt == 4'(CTRL_LEN - 1))
                                  : (cnt == 4'(DATA_LEN - 1)));
        par_good          = prev_px ^ par_b ^ flag;
        px_next           = px_run ^ bit_val;
    end

    // Purpose: NULL hunt, character assembly and the parity verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aligned    <= 1'b0;
            hist       <= '0;
            cnt        <= '0;
            par_b      <= 1'b0;
            flag       <= 1'b0;
            payload    <= '0;
            px_run     <= 1'b0;
            prev_px    <= 1'b0;
            chr_vld    <= 1'b0;
            chr_ctrl   <= 1'b0;
            chr_data   <= '0;
            align_null <= 1'b0;
            par_err    <= 1'b0;
        end else begin
            chr_vld    <= 1'b0;
            align_null <= 1'b0;
            par_err    <= 1'b0;
            if (resync) begin
                aligned <= 1'b0;
                hist    <= '0;
                cnt     <= '0;
            end else if (bit_vld) begin
                if (!aligned) begin
                    hist <= hist_next;
                    if (hist_next == NULL_TAIL) begin
                        aligned    <= 1'b1;
                        align_null <= 1'b1;
                        cnt        <= '0;
                        prev_px    <= 1'b0;
                    end
                end else if (cnt == 4'd0) begin
                    par_b   <= bit_val;
                    payload <= '0;
                    px_run  <= 1'b0;
                    cnt     <= 4'd1;
                end else if (cnt == 4'd1) begin
                    flag <= bit_val;
                    cnt  <= 4'd2;
                end else begin
                    payload <= pay_next;
                    px_run  <= px_next;
                    cnt     <= cnt + 4'd1;
                    if (is_last) begin
                        cnt <= '0;
                        if (par_good) begin
                            chr_vld  <= 1'b1;
                            chr_ctrl <= flag;
                            chr_data <= pay_next;
                            prev_px  <= px_next;
                        end else begin
                            par_err <= 1'b1;
                            aligned <= 1'b0;
                            hist    <= '0;
                        end
                    end
                end
            end
        end
    end

    // R3: a character only completes on a cycle that carried a bit.
    p_chr_on_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        chr_vld |-> $past(bit_vld));

    // R8: a parity error is a single-cycle pulse.
    p_par_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |=> !par_err);

    // R8: a parity error never comes together with a good character.
    p_par_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |-> !chr_vld);

endmodule

// File: rtl/ds_char_decode.sv
// Module: ds_char_decode
// Decodes framed characters, including the escape sequences, into FIFO
// writes, credits, NULL reports, time codes and escape errors.
// Assumes each framed character arrives as one single-cycle strobe.
module ds_char_decode
    import ds_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chr_vld,
    input  logic       chr_ctrl,
    input  logic [7:0] chr_data,
    input  logic       align_null,
    input  logic       drop_esc,
    output logic       fifo_wr,
    output logic [8:0] fifo_wdata,
    output logic       credit,
    output logic       null_seen,
    output logic       tc_valid,
    output logic [7:0] tc_value,
    output logic       esc_err
);
    logic      esc_pending;
    ctl_code_t code;

    assign code = ctl_code_t'(chr_data[1:0]);

    // Purpose: route each character by kind and track a pending ESC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            esc_pending <= 1'b0;
            fifo_wr     <= 1'b0;
            fifo_wdata  <= '0;
            credit      <= 1'b0;
            null_seen   <= 1'b0;
            tc_valid    <= 1'b0;
            tc_value    <= '0;
            esc_err     <= 1'b0;
        end else begin
            fifo_wr   <= 1'b0;
            credit    <= 1'b0;
            null_seen <= 1'b0;
            tc_valid  <= 1'b0;
            esc_err   <= 1'b0;
            if (drop_esc) begin
                esc_pending <= 1'b0;
            end else if (align_null) begin
                null_seen   <= 1'b1;
                esc_pending <= 1'b0;
            end else if (chr_vld) begin
                if (!chr_ctrl) begin
                    if (esc_pending) begin
                        tc_valid    <= 1'b1;
                        tc_value    <= chr_data;
                        esc_pending <= 1'b0;
                    end else begin
                        fifo_wr    <= 1'b1;
                        fifo_wdata <= {1'b0, chr_data};
                    end
                end else begin
                    case (code)
                        CTL_FCT: begin
                            if (esc_pending) begin
                                null_seen   <= 1'b1;
                                esc_pending <= 1'b0;
                            end else begin
                                credit <= 1'b1;
                            end
                        end
                        CTL_EOP, CTL_EEP: begin
                            if (esc_pending) begin
                                esc_err     <= 1'b1;
                                esc_pending <= 1'b0;
                            end else begin
                                fifo_wr    <= 1'b1;
                                fifo_wdata <= (code == CTL_EOP) ? 9'h100 : 9'h101;
                            end
                        end
                        default: begin
                            if (esc_pending) begin
                                esc_err     <= 1'b1;
                                esc_pending <= 1'b0;
                            end else begin
                                esc_pending <= 1'b1;
                            end
                        end
                    endcase
                end
            end
        end
    end

    // R11: at most one decoded event per cycle.
    p_one_event_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fifo_wr, credit, null_seen, tc_valid, esc_err}));

    // R5: a credit pulse needs a framed control character just before it.
    p_credit_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        credit |-> $past(chr_vld && chr_ctrl));

    // R7: a time code needs a framed data character just before it.
    p_tc_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tc_valid |-> $past(chr_vld && !chr_ctrl));

endmodule

// File: rtl/ds_link_rx.sv
// Module: ds_link_rx (top)
// Data-strobe link receiver: bit recovery, character framing with parity
// and escape decoding. Each error restarts the NULL hunt.
// Assumes clk runs at least four times the incoming bit rate.
module ds_link_rx
    import ds_rx_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 4000,
    parameter int DISC_NS       = 850,
    parameter int SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_d,
    input  logic       rx_s,
    output logic       fifo_wr,
    output logic [8:0] fifo_wdata,
    output logic       credit,
    output logic       null_seen,
    output logic       tc_valid,
    output logic [7:0] tc_value,
    output logic       err_par,
    output logic       err_esc,
    output logic       err_disc
);
    localparam int DISC_CYC = disc_limit(DISC_NS, CLK_PERIOD_PS);

    logic       bit_vld;
    logic       bit_val;
    logic       chr_vld;
    logic       chr_ctrl;
    logic [7:0] chr_data;
    logic       align_null;
    logic       frame_resync;

    assign frame_resync = err_disc | err_esc;

    ds_bit_recover #(
        .SYNC_STAGES (SYNC_STAGES),
        .DISC_CYC    (DISC_CYC)
    ) i_bits (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_d     (rx_d),
        .rx_s     (rx_s),
        .bit_vld  (bit_vld),
        .bit_val  (bit_val),
        .disc_err (err_disc)
    );

    ds_char_frame i_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_vld    (bit_vld),
        .bit_val    (bit_val),
        .resync     (frame_resync),
        .chr_vld    (chr_vld),
        .chr_ctrl   (chr_ctrl),
        .chr_data   (chr_data),
        .align_null (align_null),
        .par_err    (err_par)
    );

    ds_char_decode i_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .chr_vld    (chr_vld),
        .chr_ctrl   (chr_ctrl),
        .chr_data   (chr_data),
        .align_null (align_null),
        .drop_esc   (err_disc | err_par),
        .fifo_wr    (fifo_wr),
        .fifo_wdata (fifo_wdata),
        .credit     (credit),
        .null_seen  (null_seen),
        .tc_valid   (tc_valid),
        .tc_value   (tc_value),
        .esc_err    (err_esc)
    );

    // R8: a parity error is never reported together with a decoded event.
    p_par_alone_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_par |-> !(fifo_wr || credit || tc_valid));

endmodule

// File: tb/test_ds_link_rx.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks push expected events; a monitor pops them.
module test_ds_link_rx;
    localparam int BITP     = 6;
    localparam int DISC_CYC = (850 * 1000 + 3999) / 4000;

    localparam int K_DATA = 0, K_EOP = 1, K_EEP = 2, K_FCT = 3, K_NULL = 4,
                   K_TC = 5, K_EPAR = 6, K_EESC = 7, K_EDISC = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_d = 1'b0;
    logic       rx_s = 1'b0;
    logic       fifo_wr;
    logic [8:0] fifo_wdata;
    logic       credit;
    logic       null_seen;
    logic       tc_valid;
    logic [7:0] tc_value;
    logic       err_par;
    logic       err_esc;
    logic       err_disc;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_edge_cyc = 0;
    logic tb_px = 1'b0;
    bit done = 0;
    int exp_k[$];
    int exp_v[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ds_link_rx i_ds_link_rx (
        .clk(clk), .rst_n(rst_n), .rx_d(rx_d), .rx_s(rx_s),
        .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .credit(credit),
        .null_seen(null_seen), .tc_valid(tc_valid), .tc_value(tc_value),
        .err_par(err_par), .err_esc(err_esc), .err_disc(err_disc)
    );

    function automatic string req_of(input int k);
        case (k)
            K_DATA, K_EOP, K_EEP: return "R4";
            K_FCT:   return "R5";
            K_NULL:  return "R6";
            K_TC:    return "R7";
            K_EPAR:  return "R8";
            K_EESC:  return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic expect_ev(input int k, input int v);
        exp_k.push_back(k);
        exp_v.push_back(v);
    endtask

    // Monitor side: compare one observed event with the queue front.
    task automatic observe(input int k, input int v);
        int ek, ev;
        checks++;
        if (exp_k.size() == 0) begin
            errors++;
            $display("FAIL %s: got kind %0d val %0h, expected no event", req_of(k), k, v);
            return;
        end
        ek = exp_k.pop_front();
        ev = exp_v.pop_front();
        if (ek != k || ev != v) begin
            errors++;
            $display("FAIL %s: got kind %0d val %0h, expected kind %0d val %0h",
                     req_of(ek), k, v, ek, ev);
        end
        if (k == K_EDISC) begin
            checks++;
            if ((cyc - last_edge_cyc) < DISC_CYC || (cyc - last_edge_cyc) > DISC_CYC + 10) begin
                errors++;
                $display("FAIL R10: disconnect after %0d cycles, expected %0d to %0d",
                         cyc - last_edge_cyc, DISC_CYC, DISC_CYC + 10);
            end
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (fifo_wr) begin
                if (fifo_wdata == 9'h100)      observe(K_EOP, 0);
                else if (fifo_wdata == 9'h101) observe(K_EEP, 0);
                else                           observe(K_DATA, int'(fifo_wdata));
            end
            if (credit)    observe(K_FCT, 0);
            if (null_seen) observe(K_NULL, 0);
            if (tc_valid)  observe(K_TC, int'(tc_value));
            if (err_par)   observe(K_EPAR, 0);
            if (err_esc)   observe(K_EESC, 0);
            if (err_disc)  observe(K_EDISC, 0);
        end
    end

    // Driver: one bit in data/strobe coding, held BITP cycles.
    task automatic send_bit(input logic b);
        @(posedge clk);
        #1;
        if (b == rx_d) rx_s = ~rx_s;
        else           rx_d = b;
        last_edge_cyc = cyc;
        repeat (BITP - 1) @(posedge clk);
    endtask

    task automatic send_data(input logic [7:0] v, input logic bad);
        send_bit(1'b1 ^ tb_px ^ bad);
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
        tb_px = ^v;
    endtask

    task automatic send_ctrl(input logic first, input logic second);
        send_bit(tb_px);
        send_bit(1'b1);
        send_bit(first);
        send_bit(second);
        tb_px = first ^ second;
    endtask

    task automatic send_null();
        send_ctrl(1'b1, 1'b1);
        send_ctrl(1'b0, 1'b0);
    endtask

    task automatic drain_check(input string req);
        repeat (20) @(posedge clk);
        @(negedge clk);
        checks++;
        if (exp_k.size() != 0) begin
            errors++;
            $display("FAIL %s: %0d events missing, expected 0", req, exp_k.size());
            exp_k.delete();
            exp_v.delete();
        end
    endtask

    task automatic finish_up();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run hung, expected completion");
        finish_up();
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if ({fifo_wr, fifo_wdata, credit, null_seen, tc_valid, tc_value,
             err_par, err_esc, err_disc} != '0) begin
            errors++;
            $display("FAIL R1: outputs %0h after reset, expected 0",
                     {fifo_wr, fifo_wdata, credit, null_seen, tc_valid, tc_value,
                      err_par, err_esc, err_disc});
        end
        // R1: long idle gives no disconnect before any bit.
        repeat (DISC_CYC + 100) @(posedge clk);
        drain_check("R1");

        // R2: junk is discarded, alignment on the first NULL.
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        expect_ev(K_NULL, 0); send_null();
        expect_ev(K_NULL, 0); send_null();
        drain_check("R2");

        // R5: credits.
        expect_ev(K_FCT, 0); send_ctrl(1'b0, 1'b0);
        expect_ev(K_FCT, 0); send_ctrl(1'b0, 1'b0);
        // R4, R3: data patterns and end markers.
        expect_ev(K_DATA, 'h00); send_data(8'h00, 1'b0);
        expect_ev(K_DATA, 'hFF); send_data(8'hFF, 1'b0);
        expect_ev(K_DATA, 'hA5); send_data(8'hA5, 1'b0);
        expect_ev(K_DATA, 'h3C); send_data(8'h3C, 1'b0);
        expect_ev(K_EOP, 0);     send_ctrl(1'b0, 1'b1);
        expect_ev(K_DATA, 'h81); send_data(8'h81, 1'b0);
        expect_ev(K_EEP, 0);     send_ctrl(1'b1, 1'b0);
        // R7: time code, not written to the FIFO.
        expect_ev(K_TC, 'h2A);   send_ctrl(1'b1, 1'b1); send_data(8'h2A, 1'b0);
        // R6: NULL between data.
        expect_ev(K_NULL, 0);    send_null();
        expect_ev(K_DATA, 'h7E); send_data(8'h7E, 1'b0);
        drain_check("R4");

        // R10: a gap just under the window is tolerated.
        expect_ev(K_DATA, 'h11); send_data(8'h11, 1'b0);
        repeat (DISC_CYC - 20) @(posedge clk);
        expect_ev(K_DATA, 'h22); send_data(8'h22, 1'b0);
        drain_check("R10");

        // R8: bad parity, following bits dropped until a NULL.
        expect_ev(K_EPAR, 0);    send_data(8'h55, 1'b1);
        send_data(8'h00, 1'b0);
        expect_ev(K_NULL, 0);    send_null();
        expect_ev(K_DATA, 'h99); send_data(8'h99, 1'b0);
        drain_check("R8");

        // R9: ESC ESC, then ESC EOP.
        expect_ev(K_EESC, 0);    send_ctrl(1'b1, 1'b1); send_ctrl(1'b1, 1'b1);
        expect_ev(K_NULL, 0);    send_null();
        expect_ev(K_EESC, 0);    send_ctrl(1'b1, 1'b1); send_ctrl(1'b0, 1'b1);
        expect_ev(K_NULL, 0);    send_null();
        expect_ev(K_DATA, 'h5A); send_data(8'h5A, 1'b0);
        drain_check("R9");

        // R10: stop the lines, then recover with a NULL.
        expect_ev(K_EDISC, 0);
        repeat (DISC_CYC + 40) @(posedge clk);
        drain_check("R10");
        expect_ev(K_NULL, 0);    send_null();
        expect_ev(K_DATA, 'hC3); send_data(8'hC3, 1'b0);
        drain_check("R10");

        finish_up();
    end
endmodule